// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives asynchronous characters from the half-duplex data line of a smart card. It runs from the internal basic clock and divides it by a fixed elementary time unit (ETU) of 372 clocks per bit. A falling edge on the idle line starts the per-bit count. Each bit of the character is then sampled once, near the middle of its bit period. A character has a low start bit, eight data bits and one even-parity bit.

Two controls change how the data is read. The inverse-convention select inverts the data and parity levels. The bit-order select decides whether the first data bit on the line lands in bit 0 or in bit 7 of the stored byte. When the parity check fails, the block pulls the line low for one ETU to tell the card. It also raises a flag recording that it sent this error signal. A byte that arrives while the previous one is still unread is dropped and raises an overrun flag.

A separate enable stage turns reception on. It refuses any request that enables reception and transmission together. It also holds reception off until one full ETU has passed after reset or after any change to the two format controls.

Top module: `scard_rx`

## Requirements
- R1: When rx_req and tx_req are both high, rx_on and tx_on are both 0 two clocks later. tx_req alone sets tx_on. rx_req alone sets rx_on, subject to R2. rx_on and tx_on are never 1 together.
- R2: rx_on stays 0 until ETU_CLKS clocks have passed since reset or since the last change of inv_conv or msb_first. It rises on the second clock after the guard count completes.
- R3: A falling edge on the synchronised line in idle sets the bit counter to count 0. The counter runs 0 to ETU_CLKS-1 and then wraps. Each bit is sampled once, at count ETU_CLKS/2-1 (185 by default), so a character sent with bit periods of ETU_CLKS clocks is received intact.
- R4: If the start bit reads high at its sample point, the block returns to idle and delivers no byte. A correct character that follows is still received.
- R5: With msb_first=0, the first data bit on the line is stored in rx_data bit 0 and the last one in bit 7.
- R6: With msb_first=1, the first data bit on the line is stored in rx_data bit 7 and the last one in bit 0.
- R7: With inv_conv=1, every data and parity bit is inverted before it is stored and checked. The start bit is still recognised as a low level on rx_line.
- R8: Parity is even over the nine logical bits (data plus parity). On a mismatch, parity_err is set, no rx_valid pulse is given and rx_data keeps its old value.
- R9: On a parity error, err_drive goes high 10*ETU_CLKS+3 clocks after the clock that precedes the start edge. It stays high for exactly ETU_CLKS clocks, and errsig_flag is set.
- R10: If a good byte completes while the previous byte has not been acknowledged with rd_ack, overrun_err is set, rx_data keeps the old byte and no rx_valid pulse is given.
- R11: clr_parity, clr_overrun and clr_errsig each clear only their own flag, one clock after they are sampled.
- R12: After reset, rx_on, tx_on, rx_valid, rx_data, parity_err, overrun_err, errsig_flag and err_drive are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal basic clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial data line from the card (idle high) |
| rx_req | input | 1 | Request to enable reception |
| tx_req | input | 1 | Request to enable transmission |
| inv_conv | input | 1 | 1 = inverse convention (data and parity levels inverted) |
| msb_first | input | 1 | 1 = first data bit goes to bit 7 |
| rd_ack | input | 1 | Marks the held byte as read |
| clr_parity | input | 1 | Clears parity_err |
| clr_overrun | input | 1 | Clears overrun_err |
| clr_errsig | input | 1 | Clears errsig_flag |
| rx_on | output | 1 | Reception enabled |
| tx_on | output | 1 | Transmission enabled |
| rx_data | output | DATA_BITS | Last byte delivered |
| rx_valid | output | 1 | One-clock strobe when rx_data is loaded |
| parity_err | output | 1 | Parity mismatch flag |
| overrun_err | output | 1 | Overrun flag |
| errsig_flag | output | 1 | Set when the error signal was driven |
| err_drive | output | 1 | 1 = pull the line low (error signal) |

## Verification
The bench builds the block with its default parameters: ETU_CLKS of 372, DATA_BITS of 8 and a two-stage synchroniser. It can therefore check the 185-count sample point, the exact start and length of the error signal in clocks, and the one-ETU guard against the real timing. A character takes about 4,100 clocks at this setting, so a table of seven formats plus the directed false-start, overrun, flag-clearing and exclusion cases fits well inside the run budget. The table covers all four combinations of inversion and bit order, and includes a parity failure under the inverse convention.

// File: rtl/scard_rx_pkg.sv
package scard_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_FRAME  = 2'd1,
    RX_ERRSIG = 2'd2
  } rx_state_t;
endpackage

// File: rtl/scard_line_sync.sv
module scard_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign line_s = chain[STAGES-1];
  assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/scard_enable_ctl.sv
module scard_enable_ctl #(
  parameter int ETU_CLKS = 372
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_req,
  input  logic tx_req,
  input  logic inv_conv,
  input  logic msb_first,
  output logic rx_on,
  output logic tx_on
);
  localparam int GW = $clog2(ETU_CLKS + 1);

  logic [GW-1:0] guard;
  logic [1:0]    cfg_q;
  logic [1:0]    cfg;
  logic          settled;

  assign cfg     = {inv_conv, msb_first};
  assign settled = (guard == GW'(ETU_CLKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      guard <= '0;
      cfg_q <= cfg;
      rx_on <= 1'b0;
      tx_on <= 1'b0;
    end else begin
      cfg_q <= cfg;
      if (cfg != cfg_q)  guard <= '0;
      else if (!settled) guard <= guard + 1'b1;
      rx_on <= rx_req & ~tx_req & settled;
      tx_on <= tx_req & ~rx_req;
    end
  end

  // R1
  excl_on_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_on && tx_on));
  // R1
  both_req_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_req && tx_req) |=> (!rx_on && !tx_on));
  // R2
  guard_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_on) |-> ($past(guard) == GW'(ETU_CLKS)));
endmodule

// File: rtl/scard_frame_rx.sv
module scard_frame_rx
  import scard_rx_pkg::*;
#(
  parameter int ETU_CLKS  = 372,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 line_s,
  input  logic                 fall,
  input  logic                 inv_conv,
  input  logic                 msb_first,
  output logic                 frm_done,
  output logic [DATA_BITS-1:0] frm_byte,
  output logic                 frm_bad,
  output logic                 es_start,
  output logic                 err_drive
);
  localparam int CW       = $clog2(ETU_CLKS);
  localparam int SAMPLE   = ETU_CLKS / 2 - 1;
  localparam int LASTBIT  = DATA_BITS + 1;
  localparam int BW       = $clog2(DATA_BITS + 3);

  rx_state_t              state;
  logic [CW-1:0]          cnt;
  logic [BW-1:0]          bidx;
  logic [DATA_BITS-1:0]   sh;
  logic                   bad_q;
  logic                   lvl;
  logic                   at_sample;
  logic                   at_end;

  assign lvl       = line_s ^ inv_conv;
  assign at_sample = (cnt == CW'(SAMPLE));
  assign at_end    = (cnt == CW'(ETU_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      sh        <= '0;
      bad_q     <= 1'b0;
      frm_done  <= 1'b0;
      frm_byte  <= '0;
      frm_bad   <= 1'b0;
      es_start  <= 1'b0;
      err_drive <= 1'b0;
    end else begin
      frm_done <= 1'b0;
      es_start <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          err_drive <= 1'b0;
          if (en && fall) begin
            state <= RX_FRAME;
            cnt   <= '0;
            bidx  <= '0;
            bad_q <= 1'b0;
          end
        end
        RX_FRAME: begin
          if (!en) begin
            state <= RX_IDLE;
          end else begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + 1'b1;
            if (at_sample) begin
              if (bidx == BW'(0)) begin
                if (line_s) state <= RX_IDLE;
              end else if (bidx <= BW'(DATA_BITS)) begin
                if (msb_first) sh <= {sh[DATA_BITS-2:0], lvl};
                else           sh <= {lvl, sh[DATA_BITS-1:1]};
              end else begin
                frm_done <= 1'b1;
                frm_byte <= sh;
                frm_bad  <= (^sh) ^ lvl;
                bad_q    <= (^sh) ^ lvl;
              end
            end
            if (at_end) begin
              if (bidx == BW'(LASTBIT)) begin
                if (bad_q) begin
                  state     <= RX_ERRSIG;
                  err_drive <= 1'b1;
                  es_start  <= 1'b1;
                end else begin
                  state <= RX_IDLE;
                end
              end else begin
                bidx <= bidx + 1'b1;
              end
            end
          end
        end
        RX_ERRSIG: begin
          if (!en || at_end) begin
            state     <= RX_IDLE;
            err_drive <= 1'b0;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R3
  sample_point_chk: assert property (@(posedge clk) disable iff (rst)
    frm_done |-> ($past(cnt) == CW'(SAMPLE)));
  // R9
  errsig_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_ERRSIG && at_end) |=> !err_drive);
  // R9
  errsig_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_drive) |-> bad_q);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE) |-> !err_drive);
endmodule

// File: rtl/scard_rx_flags.sv
module scard_rx_flags #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_done,
  input  logic [DATA_BITS-1:0] frm_byte,
  input  logic                 frm_bad,
  input  logic                 es_start,
  input  logic                 rd_ack,
  input  logic                 clr_parity,
  input  logic                 clr_overrun,
  input  logic                 clr_errsig,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 parity_err,
  output logic                 overrun_err,
  output logic                 errsig_flag
);
  logic unread;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      parity_err  <= 1'b0;
      overrun_err <= 1'b0;
      errsig_flag <= 1'b0;
      unread      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rd_ack)      unread      <= 1'b0;
      if (clr_parity)  parity_err  <= 1'b0;
      if (clr_overrun) overrun_err <= 1'b0;
      if (clr_errsig)  errsig_flag <= 1'b0;
      if (es_start)    errsig_flag <= 1'b1;
      if (frm_done) begin
        if (frm_bad) begin
          parity_err <= 1'b1;
        end else if (unread && !rd_ack) begin
          overrun_err <= 1'b1;
        end else begin
          rx_data  <= frm_byte;
          rx_valid <= 1'b1;
          unread   <= 1'b1;
        end
      end
    end
  end

  // R10
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_err) |-> $stable(rx_data));
  // R10
  ovr_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_err) |-> $past(frm_done));
  // R8
  bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_done && frm_bad) |=> (!rx_valid && $stable(rx_data)));
endmodule

// File: rtl/scard_rx.sv
module scard_rx #(
  parameter int ETU_CLKS    = 372,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  input  logic                 rx_req,
  input  logic                 tx_req,
  input  logic                 inv_conv,
  input  logic                 msb_first,
  input  logic                 rd_ack,
  input  logic                 clr_parity,
  input  logic                 clr_overrun,
  input  logic                 clr_errsig,
  output logic                 rx_on,
  output logic                 tx_on,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 parity_err,
  output logic                 overrun_err,
  output logic                 errsig_flag,
  output logic                 err_drive
);
  logic                 line_s;
  logic                 fall;
  logic                 frm_done;
  logic [DATA_BITS-1:0] frm_byte;
  logic                 frm_bad;
  logic                 es_start;

  scard_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(rx_line), .line_s(line_s), .fall(fall)
  );

  scard_enable_ctl #(.ETU_CLKS(ETU_CLKS)) u_en (
    .clk(clk), .rst(rst), .rx_req(rx_req), .tx_req(tx_req),
    .inv_conv(inv_conv), .msb_first(msb_first),
    .rx_on(rx_on), .tx_on(tx_on)
  );

  scard_frame_rx #(.ETU_CLKS(ETU_CLKS), .DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst(rst), .en(rx_on), .line_s(line_s), .fall(fall),
    .inv_conv(inv_conv), .msb_first(msb_first),
    .frm_done(frm_done), .frm_byte(frm_byte), .frm_bad(frm_bad),
    .es_start(es_start), .err_drive(err_drive)
  );

  scard_rx_flags #(.DATA_BITS(DATA_BITS)) u_flags (
    .clk(clk), .rst(rst), .frm_done(frm_done), .frm_byte(frm_byte),
    .frm_bad(frm_bad), .es_start(es_start), .rd_ack(rd_ack),
    .clr_parity(clr_parity), .clr_overrun(clr_overrun), .clr_errsig(clr_errsig),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
    .overrun_err(overrun_err), .errsig_flag(errsig_flag)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rx_valid && !err_drive && !rx_on && !tx_on));
endmodule

// File: tb/sim_scard_rx.sv
`timescale 1ns/1ps
module sim_scard_rx;
  localparam int E = 372;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic rx_req = 1'b0, tx_req = 1'b0, inv_conv = 1'b0, msb_first = 1'b0;
  logic rd_ack = 1'b0, clr_parity = 1'b0, clr_overrun = 1'b0, clr_errsig = 1'b0;
  logic rx_on, tx_on, rx_valid, parity_err, overrun_err, errsig_flag, err_drive;
  logic [7:0] rx_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int vcnt = 0;
  logic [7:0] vlast = 8'h00;
  int erise = 0;
  int ehigh = 0;
  logic eprev = 1'b0;
  int mark = 0;

  // [18] inv, [17] msb_first, [16] bad parity, [15:8] sent (first bit = bit 0), [7:0] expected
  localparam logic [18:0] VEC [0:6] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF},
    {1'b0, 1'b0, 1'b1, 8'h96, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h3B, 8'hDC},
    {1'b1, 1'b1, 1'b0, 8'h01, 8'h80},
    {1'b1, 1'b0, 1'b0, 8'h5C, 8'h5C},
    {1'b1, 1'b0, 1'b1, 8'h3C, 8'h00}
  };

  scard_rx #(.ETU_CLKS(E), .DATA_BITS(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rx_req(rx_req), .tx_req(tx_req),
    .inv_conv(inv_conv), .msb_first(msb_first), .rd_ack(rd_ack),
    .clr_parity(clr_parity), .clr_overrun(clr_overrun), .clr_errsig(clr_errsig),
    .rx_on(rx_on), .tx_on(tx_on), .rx_data(rx_data), .rx_valid(rx_valid),
    .parity_err(parity_err), .overrun_err(overrun_err),
    .errsig_flag(errsig_flag), .err_drive(err_drive)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt  = vcnt + 1;
      vlast = rx_data;
    end
    if (err_drive) ehigh = ehigh + 1;
    if (err_drive && !eprev) erise = cyc;
    eprev = err_drive;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic inv, input logic [7:0] b, input logic flip);
    logic p;
    p = (^b) ^ flip;
    @(negedge clk);
    mark = cyc;
    rx_line = 1'b0;
    repeat (E) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i] ^ inv;
      repeat (E) @(negedge clk);
    end
    rx_line = p ^ inv;
    repeat (E) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic pulse_clears(input logic a, input logic pp, input logic o, input logic s);
    @(negedge clk);
    rd_ack = a; clr_parity = pp; clr_overrun = o; clr_errsig = s;
    @(negedge clk);
    rd_ack = 1'b0; clr_parity = 1'b0; clr_overrun = 1'b0; clr_errsig = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v0;
    logic [7:0] d0;
    int e0;
    string tag;
    rx_req = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(rx_on == 0 && tx_on == 0 && rx_valid == 0, "R12", {rx_on, tx_on, rx_valid}, 0);
    chk(rx_data == 0 && parity_err == 0 && overrun_err == 0 && errsig_flag == 0 && err_drive == 0,
        "R12", {rx_data, parity_err, overrun_err, errsig_flag, err_drive}, 0);
    rst = 1'b0;
    // R2 guard after reset
    repeat (E) @(negedge clk);
    chk(rx_on == 0, "R2", rx_on, 0);
    @(negedge clk);
    chk(rx_on == 1, "R2", rx_on, 1);

    for (int i = 0; i < 7; i++) begin
      logic [18:0] v;
      v = VEC[i];
      if ({v[18], v[17]} != {inv_conv, msb_first}) begin
        @(negedge clk);
        inv_conv = v[18]; msb_first = v[17];
        repeat (2) @(negedge clk);
        chk(rx_on == 0, "R2", rx_on, 0);
        repeat (E + 1) @(negedge clk);
        chk(rx_on == 1, "R2", rx_on, 1);
      end
      tag = v[18] ? "R7" : (v[17] ? "R6" : "R5");
      v0 = vcnt; d0 = rx_data; e0 = ehigh;
      send_frame(v[18], v[15:8], v[16]);
      repeat (2 * E) @(negedge clk);
      if (v[16]) begin
        chk(vcnt == v0, "R8", vcnt - v0, 0);
        chk(parity_err == 1 && rx_data == d0, "R8", {parity_err, rx_data}, {1'b1, d0});
        chk(errsig_flag == 1, "R9", errsig_flag, 1);
        chk(erise - mark == 10 * E + 3, "R9", erise - mark, 10 * E + 3);
        chk(ehigh - e0 == E, "R9", ehigh - e0, E);
        pulse_clears(1'b0, 1'b1, 1'b0, 1'b1);
      end else begin
        chk(vcnt == v0 + 1, "R3", vcnt - v0, 1);
        chk(vlast == v[7:0], tag, vlast, v[7:0]);
        chk(parity_err == 0 && err_drive == 0, "R8", {parity_err, err_drive}, 0);
        pulse_clears(1'b1, 1'b0, 1'b0, 1'b0);
      end
    end

    // back to direct convention, LSB first
    @(negedge clk);
    inv_conv = 1'b0; msb_first = 1'b0;
    repeat (E + 4) @(negedge clk);

    // R4 false start: short glitch low
    v0 = vcnt;
    rx_line = 1'b0;
    repeat (60) @(negedge clk);
    rx_line = 1'b1;
    repeat (12 * E) @(negedge clk);
    chk(vcnt == v0 && parity_err == 0, "R4", vcnt - v0, 0);
    send_frame(1'b0, 8'h6E, 1'b0);
    repeat (2 * E) @(negedge clk);
    chk(vcnt == v0 + 1 && vlast == 8'h6E, "R4", vlast, 8'h6E);

    // R10 overrun: second byte while first unread
    v0 = vcnt;
    send_frame(1'b0, 8'h12, 1'b0);
    repeat (2 * E) @(negedge clk);
    chk(overrun_err == 1, "R10", overrun_err, 1);
    chk(rx_data == 8'h6E && vcnt == v0, "R10", rx_data, 8'h6E);

    // R11: raise parity and error-signal flags too, then clear one by one
    send_frame(1'b0, 8'h40, 1'b1);
    repeat (2 * E) @(negedge clk);
    chk(parity_err && errsig_flag && overrun_err, "R11",
        {parity_err, errsig_flag, overrun_err}, 3'b111);
    pulse_clears(1'b0, 1'b0, 1'b1, 1'b0);
    chk(overrun_err == 0 && parity_err == 1 && errsig_flag == 1, "R11",
        {overrun_err, parity_err, errsig_flag}, 3'b011);
    pulse_clears(1'b0, 1'b1, 1'b0, 1'b0);
    chk(parity_err == 0 && errsig_flag == 1, "R11", {parity_err, errsig_flag}, 2'b01);
    pulse_clears(1'b1, 1'b0, 1'b0, 1'b1);
    chk(errsig_flag == 0, "R11", errsig_flag, 0);

    // after acknowledge a new byte is accepted
    v0 = vcnt;
    send_frame(1'b0, 8'hC3, 1'b0);
    repeat (2 * E) @(negedge clk);
    chk(vcnt == v0 + 1 && rx_data == 8'hC3, "R10", rx_data, 8'hC3);
    pulse_clears(1'b1, 1'b0, 1'b0, 1'b0);

    // R1 exclusion
    @(negedge clk);
    tx_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(rx_on == 0 && tx_on == 0, "R1", {rx_on, tx_on}, 0);
    rx_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_on == 1 && rx_on == 0, "R1", {rx_on, tx_on}, 2'b01);
    tx_req = 1'b0; rx_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(rx_on == 1 && tx_on == 0, "R1", {rx_on, tx_on}, 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule